// File: doc/BRIEF.md
# Integer ALU with Second-Operand Conditioning

This block is the combinational arithmetic and logic unit of a small 32-bit RISC-V style integer core. It accepts two operands and a 3-bit operation select that is taken straight from the instruction's funct3 field. It produces a result word and a zero flag. The branch logic uses the zero flag, and the register file takes the result.

Subtraction has no opcode of its own. The second operand first passes through a conditioning stage: one control inverts every bit of it, and a second control then adds one to it. The decoder sets both controls when funct3 is 0 and funct7 bit 5 is 1, so the add path computes a minus b. The same funct7 bit drives a signed flag. That flag turns the right shift into an arithmetic shift and has no effect on any other operation. Every operation uses the conditioned second operand.

Top module: `rv_int_alu`

## Requirements
- R1: With select 0, result equals a plus the conditioned operand, modulo 2^32, with no overflow indication.
- R2: The conditioned operand is b, inverted bitwise when negate is 1, plus 1 when increment is 1 (modulo 2^32). With both controls set, select 0 yields a minus b.
- R3: With select 1, result is a shifted left by the conditioned operand's low 5 bits, with zeros filling from the right.
- R4: With select 5, result is a shifted right by the conditioned operand's low 5 bits. The fill is zero when signed is 0 and copies a's bit 31 when signed is 1.
- R5: With select 2, result is 32'h1 when a is less than the conditioned operand as two's-complement numbers, otherwise 32'h0.
- R6: With select 3, result is 32'h1 when a is less than the conditioned operand as unsigned numbers, otherwise 32'h0.
- R7: Select 4 gives bitwise XOR, select 6 bitwise OR and select 7 bitwise AND of a and the conditioned operand.
- R8: The zero output is 1 exactly when all 32 result bits are 0.
- R9: For both shifts, bits 31:5 of the conditioned operand have no effect on the result.
- R10: The signed input has no effect on the result for any select other than 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand, before conditioning |
| op_sel_i | input | 3 | Operation select (funct3 encoding) |
| signed_i | input | 1 | Selects arithmetic right shift |
| negate_i | input | 1 | Invert every bit of the second operand |
| incr_i | input | 1 | Add one to the inverted or plain second operand |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result is all zeros |

## Verification
The immediate assertions sit inside combinational blocks. They assume that every input holds a known, stable value whenever the logic is evaluated, and that the select carries no X or Z bits. The bench drives all inputs from one task, just after a rising clock edge, and only with fully defined 2-state values. It reads the outputs at the falling edge, once the whole combinational path has settled.

The stimulus covers all control combinations, including increment without negate. Some of those combinations never come from the decoder, but they are legal inputs, so the properties have to hold for them too.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SLL  = 3'd1,
      OP_SLT  = 3'd2,
      OP_SLTU = 3'd3,
      OP_XOR  = 3'd4,
      OP_SR   = 3'd5,
      OP_OR   = 3'd6,
      OP_AND  = 3'd7
   } alu_op_e;
endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
   parameter int W = 32
) (
   input  logic [W-1:0] b_i,
   input  logic         negate_i,
   input  logic         incr_i,
   output logic [W-1:0] b_o
);
   localparam int PADW = W - 1;
   logic [W-1:0] inv_b;

   assign inv_b = negate_i ? ~b_i : b_i;
   assign b_o   = inv_b + {{PADW{1'b0}}, incr_i};

   always_comb begin
      // R2
      cond_pass_chk: assert (negate_i || incr_i || (b_o == b_i));
      // R2
      cond_neg_chk: assert (!(negate_i && incr_i) || ((b_o + b_i) == '0));
   end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int W      = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o
);
   localparam int PADW = W - 1;

   generate
      if (RIPPLE) begin : g_ripple
         logic [W-1:0] carry;
         assign carry[0] = cin_i;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum_o[i] = a_i[i] ^ b_i[i] ^ carry[i];
            if (i < W - 1) begin : g_cy
               assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
            end
         end
         always_comb begin
            // R1
            add_chk: assert (sum_o == (a_i + b_i + {{PADW{1'b0}}, cin_i}));
         end
      end else begin : g_native
         assign sum_o = a_i + b_i + {{PADW{1'b0}}, cin_i};
      end
   endgenerate
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int W    = 32,
   parameter int SH_W = 5
) (
   input  logic [W-1:0]    a_i,
   input  logic [SH_W-1:0] amt_i,
   input  logic            left_i,
   input  logic            arith_i,
   output logic [W-1:0]    res_o
);
   logic [W-1:0] rev_in;
   logic [W-1:0] rev_out;
   logic [W-1:0] stage [SH_W+1];
   logic         fill;

   generate
      for (genvar i = 0; i < W; i++) begin : g_rev
         assign rev_in[i]  = a_i[W-1-i];
         assign rev_out[i] = stage[SH_W][W-1-i];
      end
   endgenerate

   assign stage[0] = left_i ? rev_in : a_i;
   assign fill     = !left_i && arith_i && a_i[W-1];

   generate
      for (genvar s = 0; s < SH_W; s++) begin : g_stage
         localparam int D = 1 << s;
         assign stage[s+1] = amt_i[s] ? {{D{fill}}, stage[s][W-1:D]} : stage[s];
      end
   endgenerate

   assign res_o = left_i ? rev_out : stage[SH_W];

   always_comb begin
      // R4
      sra_sign_chk: assert (left_i || !arith_i || !a_i[W-1] || res_o[W-1]);
      // R3
      sll_low_chk: assert (!left_i || (amt_i == '0) || !res_o[0]);
      // R4
      srl_top_chk: assert (left_i || arith_i || (amt_i == '0) || !res_o[W-1]);
   end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
   parameter int W      = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         lt_s_o,
   output logic         lt_u_o
);
   logic [W:0] diff;

   alu_adder #(.W(W + 1), .RIPPLE(RIPPLE)) u_sub (
      .a_i   ({1'b0, a_i}),
      .b_i   ({1'b1, ~b_i}),
      .cin_i (1'b1),
      .sum_o (diff)
   );

   assign lt_u_o = diff[W];
   assign lt_s_o = (a_i[W-1] ^ b_i[W-1]) ? a_i[W-1] : diff[W-1];

   always_comb begin
      // R5 R6
      lt_eq_chk: assert ((diff[W-1:0] != '0) || (!lt_s_o && !lt_u_o));
      // R6
      lt_u_msb_chk: assert (!(a_i[W-1] && !b_i[W-1]) || !lt_u_o);
   end
endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
   import rv_alu_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [XLEN-1:0] opa_i,
   input  logic [XLEN-1:0] opb_i,
   input  logic [2:0]      op_sel_i,
   input  logic            signed_i,
   input  logic            negate_i,
   input  logic            incr_i,
   output logic [XLEN-1:0] result_o,
   output logic            zero_o
);
   localparam int SH_W = $clog2(XLEN);
   localparam int PADW = XLEN - 1;

   generate
      if (XLEN < 8 || (1 << SH_W) != XLEN) begin : g_bad_xlen
         $error("rv_int_alu: XLEN must be a power of two, at least 8");
      end
   endgenerate

   alu_op_e         op;
   logic [XLEN-1:0] opb_c;
   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] shifted;
   logic            lt_s;
   logic            lt_u;

   assign op = alu_op_e'(op_sel_i);

   alu_operand_cond #(.W(XLEN)) u_cond (
      .b_i      (opb_i),
      .negate_i (negate_i),
      .incr_i   (incr_i),
      .b_o      (opb_c)
   );

   alu_adder #(.W(XLEN), .RIPPLE(RIPPLE)) u_add (
      .a_i   (opa_i),
      .b_i   (opb_c),
      .cin_i (1'b0),
      .sum_o (sum)
   );

   alu_shifter #(.W(XLEN), .SH_W(SH_W)) u_shift (
      .a_i     (opa_i),
      .amt_i   (opb_c[SH_W-1:0]),
      .left_i  (op == OP_SLL),
      .arith_i (signed_i),
      .res_o   (shifted)
   );

   alu_compare #(.W(XLEN), .RIPPLE(RIPPLE)) u_cmp (
      .a_i    (opa_i),
      .b_i    (opb_c),
      .lt_s_o (lt_s),
      .lt_u_o (lt_u)
   );

   always_comb begin
      unique case (op)
         OP_ADD:  result_o = sum;
         OP_SLL:  result_o = shifted;
         OP_SLT:  result_o = {{PADW{1'b0}}, lt_s};
         OP_SLTU: result_o = {{PADW{1'b0}}, lt_u};
         OP_XOR:  result_o = opa_i ^ opb_c;
         OP_SR:   result_o = shifted;
         OP_OR:   result_o = opa_i | opb_c;
         OP_AND:  result_o = opa_i & opb_c;
         default: result_o = '0;
      endcase
   end

   assign zero_o = ~|result_o;

   always_comb begin
      // R8
      zero_match_chk: assert (zero_o == (result_o == '0));
      // R2
      sub_chk: assert (!(op == OP_ADD && negate_i && incr_i) || (result_o == (opa_i - opb_i)));
      // R5
      slt_width_chk: assert (!(op == OP_SLT || op == OP_SLTU) || (result_o[XLEN-1:1] == '0));
   end
endmodule

// File: tb/sim_rv_int_alu.sv
module sim_rv_int_alu;
   logic        clk = 1'b0;
   logic [31:0] a, b;
   logic [2:0]  op;
   logic        sgn, neg, inc;
   logic [31:0] res;
   logic        zf;
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   always #10 clk = ~clk;

   rv_int_alu u0 (
      .opa_i(a), .opb_i(b), .op_sel_i(op), .signed_i(sgn),
      .negate_i(neg), .incr_i(inc), .result_o(res), .zero_o(zf)
   );

   function automatic logic [31:0] model(logic [31:0] x, logic [31:0] y, int o,
                                         bit s, bit n, bit c);
      logic [31:0] yc;
      int sh;
      yc = (n ? ~y : y) + (c ? 32'd1 : 32'd0);
      sh = int'(yc % 32);
      case (o)
         0: return x + yc;
         1: return x << sh;
         2: return ($signed(x) < $signed(yc)) ? 32'd1 : 32'd0;
         3: return (x < yc) ? 32'd1 : 32'd0;
         4: return x ^ yc;
         5: return s ? 32'($signed(x) >>> sh) : (x >> sh);
         6: return x | yc;
         default: return x & yc;
      endcase
   endfunction

   function automatic string tag_of(int o, bit n, bit c);
      case (o)
         0: return (n || c) ? "R2" : "R1";
         1: return "R3";
         2: return "R5";
         3: return "R6";
         5: return "R4";
         default: return "R7";
      endcase
   endfunction

   task automatic compare(string tag, logic [31:0] exp);
      checks++;
      if (res !== exp) begin
         errors++;
         $display("FAIL %s result actual %h expected %h", tag, res, exp);
      end
      checks++;
      if (zf !== (exp == 32'd0)) begin
         errors++;
         $display("FAIL R8 zero actual %b expected %b", zf, exp == 32'd0);
      end
   endtask

   task automatic run(logic [31:0] x, logic [31:0] y, int o, bit s, bit n, bit c, string tag);
      @(posedge clk);
      #1;
      a = x; b = y; op = 3'(o); sgn = s; neg = n; inc = c;
      @(negedge clk);
      compare(tag, model(x, y, o, s, n, c));
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] corner [8];
      corner = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                 32'h7FFF_FFFF, 32'h0000_001F, 32'h0000_0020, 32'hDEAD_BEEF};
      a = '0; b = '0; op = '0; sgn = 0; neg = 0; inc = 0;
      @(negedge clk);
      compare("R8 reset-state", 32'd0);

      run(32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0, "R1 wrap");
      run(32'd10, 32'd3, 0, 1, 1, 1, "R2 sub");
      run(32'd3, 32'd10, 0, 1, 1, 1, "R2 sub-neg");
      run(32'd5, 32'd5, 0, 1, 1, 1, "R8 sub-zero");
      run(32'h1234, 32'h0F, 0, 0, 1, 0, "R2 negate-only");
      run(32'h1234, 32'h0F, 0, 0, 0, 1, "R2 incr-only");
      run(32'h8000_0001, 32'd31, 1, 0, 0, 0, "R3 sll31");
      run(32'h8000_0000, 32'd31, 5, 1, 0, 0, "R4 sra31");
      run(32'h8000_0000, 32'd4, 5, 0, 0, 0, "R4 srl");
      run(32'hF000_000F, 32'hFFFF_FFE3, 1, 0, 0, 0, "R9 sll-high");
      run(32'hF000_000F, 32'h0000_0123, 5, 1, 0, 0, "R9 sra-high");
      run(32'h8000_0000, 32'h1, 2, 0, 0, 0, "R5 neg<pos");
      run(32'h8000_0000, 32'h1, 3, 0, 0, 0, "R6 big>1");
      run(32'h7FFF_FFFF, 32'h7FFF_FFFF, 2, 0, 0, 0, "R5 equal");
      run(32'd2, 32'd2, 3, 0, 1, 1, "R6 cond-cmp");
      run(32'hF0F0_F0F0, 32'hFF00_FF00, 4, 1, 0, 0, "R10 xor-signed");
      run(32'hF0F0_F0F0, 32'hFF00_FF00, 6, 0, 0, 0, "R7 or");
      run(32'hF0F0_F0F0, 32'h0F0F_0F0F, 7, 1, 0, 0, "R10 and-signed");
      run(32'h8000_0000, 32'h1, 2, 1, 0, 0, "R10 slt-signed");
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] x, y;
         int o;
         bit s, n, c;
         x = (i % 5 == 0) ? corner[$urandom % 8] : $urandom;
         y = (i % 7 == 0) ? corner[$urandom % 8] : $urandom;
         o = int'($urandom % 8);
         s = 1'($urandom);
         n = 1'($urandom);
         c = 1'($urandom);
         run(x, y, o, s, n, c, tag_of(o, n, c));
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule